// File: doc/BRIEF.md
# Pipelined Converter Redundancy Corrector

This block is the digital back end of a seven-stage pipelined analog-to-digital converter. Each conversion clock edge brings a fresh 2-bit raw code from every stage. Stages resolve two per clock cycle, so the codes that belong to one sample reach the block spread over four edges. The block sends each stage's code through a delay chain of its own length, so that the fourteen raw bits of one sample line up in the same cycle. It then overlap-adds them into a single corrected 8-bit word in straight offset binary. The word saturates at full scale and clamps at zero.

The output register drives a word on every clock. Two plain control pins govern the outputs. `oe_n` is an active-low output enable. `pwrdn` is a power-down request. The output data would float when either one disables it, and the block models that with the `data_oe` drive-enable signal instead of a tristate net. `data_valid` marks the words that come entirely from stage codes presented after reset or after power-down was released. The converter cannot stall, so there is no ready signal and no back-pressure. A sink must accept every word for which `data_valid` is high, in the cycle in which it is shown.

Top module: `pipeadc_corrector`

## Requirements
- R1: Stage k (k = 1..7) drives `stage_codes[2k-1:2k-2]` and carries weight 2^(7-k). The stage code for a sample taken at rising edge s is presented at edge s+ceil(k/2). Stages 1 and 2 arrive together, then stages 3 and 4, then 5 and 6, and stage 7 arrives last.
- R2: `data_out` shows sum(code_k * 2^(7-k)) - 32 for one sample. The word appears after the rising edge that follows the edge at which stage 7's code was presented, which is 5 edges after the sampling edge.
- R3: When the corrected value exceeds 255, `data_out` is 0xFF.
- R4: When the corrected value is negative, `data_out` is 0x00.
- R5: `data_oe` is high exactly when `oe_n` is low and `pwrdn` is low, in the same cycle and with no clock edge in between.
- R6: While `pwrdn` is high, `data_valid` is low in the same cycle.
- R7: After `pwrdn` falls, `data_valid` stays low for the first 5 cycles. It rises after the 5th rising edge sampled with `pwrdn` low. From then on it tracks R2 words built only from codes presented after the release.
- R8: While `rst_n` is low, `data_out` is 0x00 and `data_valid` is low. After release, `data_valid` refills exactly as in R7.
- R9: `oe_n` has no effect on `data_out` or `data_valid`. The words keep following R2 while the outputs are disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| stage_codes | input | 14 | Raw 2-bit codes of stages 1..7, with stage 1 in the low bits |
| pwrdn | input | 1 | Power-down request, active high |
| oe_n | input | 1 | Output enable, active low |
| data_out | output | 8 | Corrected word, straight offset binary |
| data_valid | output | 1 | High when `data_out` holds a fully refilled sample |
| data_oe | output | 1 | Drive enable for `data_out`; low means high impedance |

## Verification
A corrected word is due one rising edge after stage 7's code is presented, which is 5 edges after the sampling edge. `data_oe` and `data_valid` respond to `pwrdn` and `oe_n` in the same cycle. The refill of `data_valid` is due after the 5th edge with `pwrdn` low. The bench changes inputs and compares outputs at the falling edge. It keeps a queue of the vectors presented at each rising edge and picks stage k's code from the entry 4 - floor((k-1)/2) edges back. It counts edges since reset or power-down to predict validity. Directed holds of one vector long enough to fill the pipeline give fixed expected values at the saturation and clamp boundaries.

// File: rtl/pipeadc_pkg.sv
package pipeadc_pkg;

  // Edges between the first and the last stage group of one sample
  function automatic int skew_of(input int nstages, input int per_cycle);
    return (nstages - 1) / per_cycle;
  endfunction

  // Depth of the delay chain for zero-based stage index idx
  function automatic int chain_depth(input int nstages, input int per_cycle, input int idx);
    return skew_of(nstages, per_cycle) - idx / per_cycle + 1;
  endfunction

endpackage

// File: rtl/pipeadc_stage_align.sv
module pipeadc_stage_align
  import pipeadc_pkg::*;
#(
  parameter int NSTAGES = 7,
  parameter int CODE_W  = 2,
  parameter int SPC     = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NSTAGES*CODE_W-1:0]   codes_in,
  output logic [NSTAGES*CODE_W-1:0]   codes_out
);

  for (genvar i = 0; i < NSTAGES; i++) begin : g_stage
    localparam int DEPTH = chain_depth(NSTAGES, SPC, i);
    logic [CODE_W-1:0] dly [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int j = 0; j < DEPTH; j++) dly[j] <= '0;
      end else begin
        dly[0] <= codes_in[i*CODE_W +: CODE_W];
        for (int j = 1; j < DEPTH; j++) dly[j] <= dly[j-1];
      end
    end

    assign codes_out[i*CODE_W +: CODE_W] = dly[DEPTH-1];
  end

endmodule

// File: rtl/pipeadc_merge.sv
module pipeadc_merge #(
  parameter int NSTAGES = 7,
  parameter int CODE_W  = 2,
  parameter int OUT_W   = 8,
  parameter int OFFSET  = 32
) (
  input  logic [NSTAGES*CODE_W-1:0] aligned,
  output logic [OUT_W-1:0]          word
);

  localparam int MAXSUM = ((1 << CODE_W) - 1) * ((1 << NSTAGES) - 1);
  localparam int ACC_W  = $clog2(MAXSUM + OFFSET + 1) + 2;
  localparam int TOP    = (1 << OUT_W) - 1;

  logic signed [ACC_W-1:0] acc;

  always_comb begin
    acc = '0;
    acc = acc - $signed(ACC_W'(OFFSET));
    for (int i = 0; i < NSTAGES; i++) begin
      acc = acc + $signed(ACC_W'(aligned[i*CODE_W +: CODE_W]) << (NSTAGES - 1 - i));
    end
    if (acc < 0)
      word = '0;
    else if (acc > $signed(ACC_W'(TOP)))
      word = '1;
    else
      word = acc[OUT_W-1:0];
  end

endmodule

// File: rtl/pipeadc_refill.sv
module pipeadc_refill #(
  parameter int LATENCY = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwrdn,
  output logic filled
);

  localparam int CW = $clog2(LATENCY + 1);

  logic [CW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      left <= CW'(LATENCY);
    else if (pwrdn)
      left <= CW'(LATENCY);
    else if (left != '0)
      left <= left - 1'b1;
  end

  assign filled = (left == '0) && !pwrdn;

endmodule

// File: rtl/pipeadc_corrector.sv
module pipeadc_corrector
  import pipeadc_pkg::*;
#(
  parameter int NSTAGES = 7,
  parameter int CODE_W  = 2,
  parameter int SPC     = 2,
  parameter int OUT_W   = 8,
  parameter int OFFSET  = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NSTAGES*CODE_W-1:0] stage_codes,
  input  logic                      pwrdn,
  input  logic                      oe_n,
  output logic [OUT_W-1:0]          data_out,
  output logic                      data_valid,
  output logic                      data_oe
);

  localparam int SKEW    = skew_of(NSTAGES, SPC);
  localparam int LATENCY = SKEW + 2;

  logic [NSTAGES*CODE_W-1:0] aligned;
  logic [OUT_W-1:0]          merged;

  pipeadc_stage_align #(
    .NSTAGES (NSTAGES),
    .CODE_W  (CODE_W),
    .SPC     (SPC)
  ) u_align (
    .clk       (clk),
    .rst_n     (rst_n),
    .codes_in  (stage_codes),
    .codes_out (aligned)
  );

  pipeadc_merge #(
    .NSTAGES (NSTAGES),
    .CODE_W  (CODE_W),
    .OUT_W   (OUT_W),
    .OFFSET  (OFFSET)
  ) u_merge (
    .aligned (aligned),
    .word    (merged)
  );

  pipeadc_refill #(
    .LATENCY (LATENCY)
  ) u_refill (
    .clk    (clk),
    .rst_n  (rst_n),
    .pwrdn  (pwrdn),
    .filled (data_valid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_out <= '0;
    else        data_out <= merged;
  end

  assign data_oe = !oe_n && !pwrdn;

endmodule

// File: rtl/pipeadc_corrector_chk.sv
module pipeadc_corrector_chk #(
  parameter int OUT_W   = 8,
  parameter int LATENCY = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwrdn,
  input logic             oe_n,
  input logic [OUT_W-1:0] data_out,
  input logic             data_valid,
  input logic             data_oe
);

  logic [7:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              run <= '0;
    else if (pwrdn)          run <= '0;
    else if (run != 8'hFF)   run <= run + 8'd1;
  end

  AST_NO_UNKNOWN_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(data_out)); // R2

  AST_DRIVE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_n || pwrdn) |-> !data_oe); // R5

  AST_DRIVE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n && !pwrdn) |-> data_oe); // R5

  AST_PWRDN_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    pwrdn |-> !data_valid); // R6

  AST_REFILL_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> (32'(run) >= LATENCY)); // R7

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> (data_out == '0 && !data_valid)); // R8

endmodule

bind pipeadc_corrector pipeadc_corrector_chk #(
  .OUT_W   (OUT_W),
  .LATENCY (LATENCY)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pwrdn      (pwrdn),
  .oe_n       (oe_n),
  .data_out   (data_out),
  .data_valid (data_valid),
  .data_oe    (data_oe)
);

// File: tb/tb_pipeadc_corrector.sv
module tb_pipeadc_corrector;

  localparam int NST  = 7;
  localparam int LAT  = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] stage_codes = '0;
  logic        pwrdn = 1'b0;
  logic        oe_n = 1'b0;
  logic [7:0]  data_out;
  logic        data_valid;
  logic        data_oe;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  int rel = 0;
  logic [13:0] hist [$];
  string cur_tag = "R2";

  pipeadc_corrector dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .stage_codes (stage_codes),
    .pwrdn       (pwrdn),
    .oe_n        (oe_n),
    .data_out    (data_out),
    .data_valid  (data_valid),
    .data_oe     (data_oe)
  );

  always #10 clk = ~clk;

  // Reference state: edges since reset or power-down, and presented vectors
  always @(posedge clk) begin
    if (!rst_n) begin
      rel = 0;
      hist.delete();
    end else begin
      if (pwrdn) rel = 0;
      else if (rel < 100000) rel++;
      hist.push_back(stage_codes);
      if (hist.size() > 16) void'(hist.pop_front());
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int ref_word();
    int acc = -32;
    for (int i = 0; i < NST; i++) begin
      logic [13:0] v = hist[hist.size() - 1 - (LAT - 1 - i / 2)];
      acc += int'(v[2*i +: 2]) << (NST - 1 - i);
    end
    if (acc < 0) acc = 0;
    if (acc > 255) acc = 255;
    return acc;
  endfunction

  task automatic compare_all();
    bit exp_valid;
    bit exp_oe;
    if (!rst_n) begin
      chk(data_out == 8'd0, "R8 data_out in reset", int'(data_out), 0);
      chk(!data_valid, "R8 data_valid in reset", int'(data_valid), 0);
      return;
    end
    exp_oe = !oe_n && !pwrdn;
    chk(data_oe == exp_oe, "R5 data_oe", int'(data_oe), int'(exp_oe));
    exp_valid = !pwrdn && rel >= LAT;
    chk(data_valid == exp_valid, pwrdn ? "R6 data_valid" : "R7 data_valid",
        int'(data_valid), int'(exp_valid));
    if (exp_valid)
      chk(int'(data_out) == ref_word(), oe_n ? "R9 data_out" : cur_tag,
          int'(data_out), ref_word());
  endtask

  task automatic cyc(input logic [13:0] v, input logic pd, input logic oe);
    @(negedge clk);
    compare_all();
    stage_codes = v;
    pwrdn = pd;
    oe_n = oe;
  endtask

  function automatic logic [13:0] pack7(input int c1, input int c2, input int c3,
                                        input int c4, input int c5, input int c6,
                                        input int c7);
    return {2'(c7), 2'(c6), 2'(c5), 2'(c4), 2'(c3), 2'(c2), 2'(c1)};
  endfunction

  task automatic directed(input logic [13:0] v, input int exp, input string tag);
    cur_tag = tag;
    repeat (6) cyc(v, 1'b0, 1'b0);
    cyc(v, 1'b0, 1'b0);
    chk(int'(data_out) == exp && data_valid, tag, int'(data_out), exp);
  endtask

  initial begin
    // R8: reset state
    repeat (3) @(negedge clk);
    compare_all();
    @(negedge clk);
    rst_n = 1'b1;

    // R1: one stage at a time carries code 2
    directed(pack7(2,0,0,0,0,0,0), 96, "R1 stage1 weight");
    directed(pack7(0,2,0,0,0,0,0), 32, "R1 stage2 weight");
    directed(pack7(0,0,0,0,0,0,3), 0,  "R1 stage7 weight");
    directed(pack7(1,1,1,1,1,1,1), 95, "R2 all ones");
    // R4: clamp boundary
    directed(pack7(0,0,0,0,0,0,0), 0,  "R4 all zero");
    directed(pack7(0,1,0,0,0,0,0), 0,  "R4 exactly offset");
    directed(pack7(0,1,0,0,0,0,1), 1,  "R4 one above offset");
    // R3: saturation boundary
    directed(pack7(3,2,1,1,1,1,0), 254, "R3 below top");
    directed(pack7(3,2,1,1,1,1,1), 255, "R3 at top");
    directed(pack7(3,2,1,1,1,1,2), 255, "R3 above top");
    directed(pack7(3,3,3,3,3,3,3), 255, "R3 all three");

    // R2 and R9: random streams, oe_n toggling
    cur_tag = "R2 random stream";
    for (int n = 0; n < 1500; n++)
      cyc(14'($urandom), 1'b0, ($urandom % 4) == 0);

    // R6 and R7: power-down bursts inside a random stream
    begin
      logic pd = 1'b0;
      for (int n = 0; n < 3000; n++) begin
        if (($urandom % 30) == 0) pd = ~pd;
        cyc(14'($urandom), pd, ($urandom % 5) == 0);
      end
    end

    // R7: explicit release count
    repeat (4) cyc(14'($urandom), 1'b1, 1'b0);
    for (int n = 0; n < LAT; n++) begin
      cyc(14'($urandom), 1'b0, 1'b0);
      chk(!data_valid, "R7 refill window", int'(data_valid), 0);
    end
    cyc(14'($urandom), 1'b0, 1'b0);
    chk(data_valid, "R7 valid after refill", int'(data_valid), 1);

    // R8: reset mid-stream, then refill
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) cyc(14'($urandom), 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    cur_tag = "R8 after reset";
    repeat (20) cyc(14'($urandom), 1'b0, 1'b0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule